// File: doc/BRIEF.md
# Paced MIDI Transmit Queue

This block holds up to sixteen outgoing MIDI bytes and releases them at a fixed rate. Software writes bytes into a data register, and they join the back of the queue. A pacing counter runs on an external tick enable. Each byte leaves 170 ticks after the one before it, and the first byte leaves 170 ticks after it was written into an empty queue. A released byte appears on the output for exactly one clock, flagged by a valid strobe. There is no back-pressure.

When the last queued byte leaves, a sticky transmit-request flag is raised. This flag can drive an interrupt line. A control register holds a transmitter reset bit, which freezes the queue without emptying it, and an interrupt mask bit. A data write while sixteen bytes are already queued is reported through a sticky overflow flag. In that case the new byte takes the place of the oldest one. Both status flags stay set until a status-read strobe clears them.

Top module: `midi_tx_pacer`

## Requirements
- R1: After synchronous reset the status byte is 0x00, the control byte is 0x0A (transmitter reset bit 3 and receiver reset bit 1 set), `irq` is low and `tx_valid` is low.
- R2: Bytes leave in the order they were written. Each byte is shown on `tx_byte` for one cycle with `tx_valid` high.
- R3: A data write into an empty queue loads the pacing count with 169. The byte is released at the 170th clock edge with `tick` high after the write edge, and `tx_valid` is high in the cycle after that edge.
- R4: While the queue is not empty and the transmitter is not held, bytes are released every 170 ticks. Cycles with `tick` low neither advance nor reset the spacing, and `tx_valid` is never high on two consecutive cycles.
- R5: When a release leaves the queue empty, status bit 3 (transmit request) is set. Every data write clears it, and a write wins over a release in the same cycle.
- R6: A `stat_rd` strobe clears status bits 3 and 7 at the next edge. A flag-setting event in the same cycle wins over the clear.
- R7: A data write while 16 bytes are queued sets status bit 7 (overflow). The oldest byte is dropped, so 16 bytes stay queued, the newest last.
- R8: While control bit 3 is 1 no byte is released and the queue contents and pacing count are held. Data writes are still queued.
- R9: `irq` is high exactly when status bit 3 is 1 and control bits 3 and 2 are both 0.
- R10: A control write (`wr_sel`=0) stores the whole byte, which is visible on `ctrl_q` from the next cycle. Control changes take effect for releases from the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Pacing tick enable, one count per cycle it is high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control register, 1 data (queue) register |
| wr_data | input | 8 | Write data |
| stat_rd | input | 1 | Status read strobe; clears the sticky flags |
| status | output | 8 | Bit 7 overflow, bit 3 transmit request, others 0 |
| ctrl_q | output | 8 | Current control register value |
| irq | output | 1 | Transmit-request interrupt |
| tx_valid | output | 1 | One-cycle strobe for a released byte |
| tx_byte | output | 8 | Released byte, valid while `tx_valid` is high |

## Verification
A behavioural queue model in the bench is compared with the design on every clock, and the design is driven with several distinct patterns. A three-byte burst under a continuous tick pins down the first-byte delay and the 170-tick spacing, which separates a count that is off by one from a correct one. A tick every other cycle shows that idle cycles freeze the spacing and do not restart it. An eighteen-byte burst into a held transmitter forces two overflows. The masked drain that follows then shows which bytes survived, that the queue did not move while held, and that the interrupt stays low when masked even though the request flag rises.

// File: rtl/midi_tx_pkg.sv
// Package: shared constants for the paced MIDI transmit queue.
// Assumes byte-wide registers; bit positions are decoded by software.
package midi_tx_pkg;
    localparam int unsigned BUS_W        = 8;
    localparam int unsigned TX_RST_BIT   = 3;
    localparam int unsigned TX_MASK_BIT  = 2;
    localparam int unsigned RX_RST_BIT   = 1;
    localparam int unsigned STAT_TRQ_BIT = 3;
    localparam int unsigned STAT_OVF_BIT = 7;
    localparam logic [BUS_W-1:0] CTRL_RESET_VAL =
        (BUS_W'(1) << TX_RST_BIT) | (BUS_W'(1) << RX_RST_BIT);
endpackage

// File: rtl/mtp_fifo.sv
// Module: circular byte store with wrapping pointers and a separate empty flag.
// A pop is applied before a push in the same cycle. A push into a full store
// overwrites the oldest entry and advances the read pointer with it.
// Assumes pop is only requested while the store is not empty.
module mtp_fifo #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic              empty,
    output logic              full,
    output logic              drain,
    output logic              overflow_evt
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] rd_ptr, wr_ptr, rd_inc, rd_mid, rd_nxt, wr_nxt;
    logic              empty_q, empty_mid, full_mid, empty_nxt;

    // Post-pop view of the store, then the push applied on top of it.
    always_comb begin
        rd_inc       = rd_ptr + 1'b1;
        drain        = pop && (rd_inc == wr_ptr);
        empty_mid    = empty_q || drain;
        rd_mid       = pop ? rd_inc : rd_ptr;
        full_mid     = !empty_mid && (rd_mid == wr_ptr);
        overflow_evt = push && full_mid;
        rd_nxt       = rd_mid;
        wr_nxt       = wr_ptr;
        empty_nxt    = empty_mid;
        if (push) begin
            wr_nxt    = wr_ptr + 1'b1;
            empty_nxt = 1'b0;
            if (empty_mid) begin
                rd_nxt = wr_ptr;
            end else if (full_mid) begin
                rd_nxt = rd_mid + 1'b1;
            end
        end
    end

    // Pointer and empty-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            empty_q <= 1'b1;
        end else begin
            rd_ptr  <= rd_nxt;
            wr_ptr  <= wr_nxt;
            empty_q <= empty_nxt;
        end
    end

    // Storage write port.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    assign head_data = mem[rd_ptr];
    assign empty     = empty_q;
    assign full      = !empty_q && (rd_ptr == wr_ptr);

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);                                              // R2
    AST_OVERFLOW_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_evt |=> full);                                       // R7
endmodule

// File: rtl/mtp_pacer.sv
// Module: release pacing counter and registered output stage.
// Counts ticks while data is queued and the transmitter is not held; a zero
// count releases the head byte and reloads SPACING-1. A load request (write
// into an empty queue) restarts the spacing.
module mtp_pacer #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned SPACING = 170
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              hold,
    input  logic              q_empty,
    input  logic              load,
    input  logic [DATA_W-1:0] head_data,
    output logic              pop,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_byte
);
    localparam int unsigned CNT_W = (SPACING > 1) ? $clog2(SPACING) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SPACING - 1);

    logic [CNT_W-1:0] cnt;
    logic             active;

    assign active = tick && !hold && !q_empty;
    assign pop    = active && (cnt == '0);

    // Pacing count: restart on load or release, otherwise step down per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load || pop) begin
            cnt <= RELOAD;
        end else if (active) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Output stage: one-cycle strobe carrying the released byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= pop;
            if (pop) begin
                tx_byte <= head_data;
            end
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid);                                      // R4
endmodule

// File: rtl/mtp_regs.sv
// Module: control register, sticky status flags and interrupt output.
// Order inside one cycle: status-read clear, then release/overflow set, then
// data-write clear of the transmit request.
module mtp_regs
    import midi_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             data_wr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             stat_rd,
    input  logic             drain,
    input  logic             overflow_evt,
    output logic [BUS_W-1:0] ctrl_q,
    output logic [BUS_W-1:0] status,
    output logic             irq
);
    logic trq_q, ovf_q;

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET_VAL;
        end else if (ctrl_wr) begin
            ctrl_q <= wr_data;
        end
    end

    // Sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trq_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            trq_q <= ((trq_q && !stat_rd) || drain) && !data_wr;
            ovf_q <= (ovf_q && !stat_rd) || overflow_evt;
        end
    end

    always_comb begin
        status               = '0;
        status[STAT_TRQ_BIT] = trq_q;
        status[STAT_OVF_BIT] = ovf_q;
    end

    assign irq = trq_q && !ctrl_q[TX_RST_BIT] && !ctrl_q[TX_MASK_BIT];

    AST_WRITE_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        data_wr |=> !status[STAT_TRQ_BIT]);                           // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !drain && !overflow_evt) |=> (status == '0));     // R6
    AST_OVERFLOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_evt |=> status[STAT_OVF_BIT]);                       // R7
endmodule

// File: rtl/midi_tx_pacer.sv
// Module: top of the paced MIDI transmit queue.
// Decodes writes, joins the store, the pacer and the register block.
// Assumes tick is a synchronous enable and stat_rd a one-cycle strobe.
module midi_tx_pacer
    import midi_tx_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned SPACING = 170
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    input  logic             stat_rd,
    output logic [BUS_W-1:0] status,
    output logic [BUS_W-1:0] ctrl_q,
    output logic             irq,
    output logic             tx_valid,
    output logic [BUS_W-1:0] tx_byte
);
    logic             ctrl_wr, data_wr, pop, q_empty, q_full, drain, ovf_evt, load;
    logic [BUS_W-1:0] head_data;

    assign ctrl_wr = wr_en && !wr_sel;
    assign data_wr = wr_en && wr_sel;
    assign load    = data_wr && (q_empty || drain);

    mtp_fifo #(.DATA_W(BUS_W), .ADDR_W(ADDR_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(data_wr), .push_data(wr_data),
        .pop(pop), .head_data(head_data), .empty(q_empty), .full(q_full),
        .drain(drain), .overflow_evt(ovf_evt)
    );

    mtp_pacer #(.DATA_W(BUS_W), .SPACING(SPACING)) u_pacer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold(ctrl_q[TX_RST_BIT]),
        .q_empty(q_empty), .load(load), .head_data(head_data), .pop(pop),
        .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    mtp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .data_wr(data_wr),
        .wr_data(wr_data), .stat_rd(stat_rd), .drain(drain),
        .overflow_evt(ovf_evt), .ctrl_q(ctrl_q), .status(status), .irq(irq)
    );

    AST_HELD_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[TX_RST_BIT] |=> !tx_valid);                            // R8
    AST_FULL_BLOCKS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !drain);                                           // R7
endmodule

// File: tb/midi_tx_pacer_bench.sv
module midi_tx_pacer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       stat_rd = 1'b0;
    logic [7:0] status, ctrl_q, tx_byte;
    logic       irq, tx_valid;

    always #2 clk = ~clk;  // 250 MHz

    midi_tx_pacer u_midi_tx_pacer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .stat_rd(stat_rd), .status(status), .ctrl_q(ctrl_q),
        .irq(irq), .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int pops = 0;
    int pop_cyc [$];
    int tick_mode = 0;   // 0 every cycle, 1 every other cycle

    // behavioural reference
    logic [7:0] q [$];
    int         m_cnt = 0;
    bit         m_trq = 0, m_ovf = 0, m_valid = 0;
    logic [7:0] m_byte = 8'h00, m_ctrl = 8'h0A;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            q.delete(); m_cnt = 0; m_trq = 0; m_ovf = 0; m_valid = 0; m_ctrl = 8'h0A;
        end else begin
            m_valid = 0;
            if (stat_rd) begin m_trq = 0; m_ovf = 0; end
            if (tick && !m_ctrl[3] && q.size() > 0) begin
                if (m_cnt == 0) begin
                    m_cnt = 169; m_byte = q.pop_front(); m_valid = 1;
                    if (q.size() == 0) m_trq = 1;
                end else m_cnt--;
            end
            if (wr_en) begin
                if (wr_sel) begin
                    m_trq = 0;
                    if (q.size() == 0) m_cnt = 169;
                    if (q.size() == 16) begin void'(q.pop_front()); m_ovf = 1; end
                    q.push_back(wr_data);
                end else m_ctrl = wr_data;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk(tx_valid == m_valid, "R3 tx_valid", tx_valid, m_valid);
            if (m_valid) chk(tx_byte == m_byte, "R2 tx_byte", tx_byte, m_byte);
            chk(status[3] == m_trq, "R5 status[3]", status[3], m_trq);
            chk(status[7] == m_ovf, "R7 status[7]", status[7], m_ovf);
            chk(irq == (m_trq && !m_ctrl[3] && !m_ctrl[2]), "R9 irq", irq,
                m_trq && !m_ctrl[3] && !m_ctrl[2]);
            chk(ctrl_q == m_ctrl, "R10 ctrl_q", ctrl_q, m_ctrl);
            if (tx_valid) begin pops++; pop_cyc.push_back(cyc); end
        end
    end

    // tick generator
    always @(negedge clk) begin
        tick <= (tick_mode == 0) ? 1'b1 : cyc[0];
    end

    task automatic wr(input bit sel, input logic [7:0] d, output int wcyc);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d; wcyc = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_status();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic wait_pops(input int n);
        for (int i = 0; i < 20000 && pops < n; i++) @(negedge clk);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 150000; i++) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        int w0, wd, p0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(status == 8'h00, "R1 status", status, 8'h00);
        chk(ctrl_q == 8'h0A, "R1 ctrl_q", ctrl_q, 8'h0A);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        chk(tx_valid == 1'b0, "R1 tx_valid", tx_valid, 0);

        // burst of three under continuous tick
        wr(1'b0, 8'h00, wd);
        wr(1'b1, 8'hA1, w0);
        wr(1'b1, 8'hB2, wd);
        wr(1'b1, 8'hC3, wd);
        wait_pops(3);
        chk(pop_cyc.size() >= 3, "R2 count", pop_cyc.size(), 3);
        if (pop_cyc.size() >= 3) begin
            chk(pop_cyc[0] - w0 == 170, "R3 first delay", pop_cyc[0] - w0, 170);
            chk(pop_cyc[1] - pop_cyc[0] == 170, "R4 spacing", pop_cyc[1] - pop_cyc[0], 170);
            chk(pop_cyc[2] - pop_cyc[1] == 170, "R4 spacing", pop_cyc[2] - pop_cyc[1], 170);
        end
        @(negedge clk);
        chk(status[3] == 1'b1 && irq == 1'b1, "R5 drain request", {status[3], irq}, 3);
        rd_status();
        chk(status == 8'h00, "R6 read clear", status, 8'h00);

        // sparse tick: idle cycles freeze spacing
        tick_mode = 1;
        p0 = pops;
        wr(1'b1, 8'h5A, wd);
        wr(1'b1, 8'h3C, wd);
        wait_pops(p0 + 2);
        chk(pop_cyc[p0 + 1] - pop_cyc[p0] == 340, "R4 sparse spacing",
            pop_cyc[p0 + 1] - pop_cyc[p0], 340);
        tick_mode = 0;
        rd_status();

        // held transmitter, overflow twice
        wr(1'b0, 8'h08, wd);
        p0 = pops;
        for (int i = 0; i < 18; i++) wr(1'b1, 8'(8'h10 + i), wd);
        repeat (400) @(negedge clk);
        chk(pops == p0, "R8 held release count", pops - p0, 0);
        chk(status[7] == 1'b1, "R7 overflow flag", status[7], 1);

        // masked drain: 16 bytes survive, irq stays low
        wr(1'b0, 8'h04, wd);
        wait_pops(p0 + 16);
        repeat (400) @(negedge clk);
        chk(pops - p0 == 16, "R7 survivors", pops - p0, 16);
        chk(status[3] == 1'b1 && irq == 1'b0, "R9 masked irq", {status[3], irq}, 2);
        wr(1'b0, 8'h00, wd);
        @(negedge clk);
        chk(irq == 1'b1, "R9 unmasked irq", irq, 1);
        wr(1'b1, 8'h77, wd);
        @(negedge clk);
        chk(status[3] == 1'b0, "R5 write clears", status[3], 0);
        wait_pops(p0 + 17);
        repeat (3) @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule